// File: doc/BRIEF.md
# Deep Power-Down Sequencer

This block sits on the controller side of a low-power DDR memory and takes the device into and out of its deepest sleep state. When the host asks for sleep, the sequencer checks the bank-open status. If any bank is still open, it first closes every bank with a precharge-all command and waits out the precharge time. Once all banks are closed, it issues the burst-terminate command encoding while driving the clock enable low, and acknowledges the host.

In deep sleep the array loses its contents. A wake request may arrive asynchronously, so it passes through a synchronizer. Once the minimum low time of the clock enable has passed, the wake request raises the clock enable. The block then counts the long power-up pause, measured in clock cycles and derived from the clock frequency. After the pause it starts the separate initialization engine through a start/done handshake. It reports ready only when that engine reports done, and it raises a data-lost flag to the host on every exit.

The block assumes the device is initialized and idle when reset is released. Only NOP leaves the command bus from the entry command until initialization starts.

Top module: `dpd_seq`

## Requirements
- R1: After reset, the outputs are cke=1, ready=1, cmd=NOP (3'b111), pre_all=0, sleep_ack=0, init_start=0 and data_lost=0.
- R2: A sleep_req sampled while idle with all banks closed puts the burst-terminate code (3'b110) on cmd, together with cke=0 and a one-cycle sleep_ack, in the cycle after that edge. ready drops in the same cycle.
- R3: If any banks_open bit is set when entry is decided, the block issues a precharge-all (cmd 3'b010, pre_all=1) instead, then NOP for T_RP-1 cycles. It decides again T_RP cycles after the precharge: burst-terminate if all banks are closed, another precharge-all otherwise.
- R4: From the burst-terminate cycle until init_start, cmd carries only NOP apart from that burst-terminate cycle.
- R5: Once cke goes low it stays low for at least T_CKE cycles. A wake request that arrives earlier takes effect exactly T_CKE cycles after cke fell.
- R6: A wake_req raised while asleep, with the low time met, raises cke SYNC_STAGES+1 clock edges after it is applied.
- R7: init_start pulses for exactly one cycle, CLK_MHZ*PAUSE_US cycles after cke rises, with cke held high throughout.
- R8: ready stays low from the acceptance of sleep until init_done is sampled during initialization, and goes high in the following cycle.
- R9: data_lost goes high in the cycle cke rises on exit, and stays high until the next sleep request is accepted, which clears it.
- R10: wake_req has no effect while idle (cke, cmd and ready unchanged), and sleep_req has no effect while the block is asleep or pausing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Host request to enter deep sleep |
| wake_req | input | 1 | Host wake request, may be asynchronous |
| banks_open | input | NBANK | One bit per bank, set while that bank has an open row |
| init_done | input | 1 | Initialization engine reports completion |
| cmd | output | 3 | Command code {ras_n, cas_n, we_n} |
| pre_all | output | 1 | All-banks qualifier, high with a precharge |
| cke | output | 1 | Clock enable to the memory |
| sleep_ack | output | 1 | One-cycle pulse when the entry command is issued |
| init_start | output | 1 | One-cycle pulse that starts the initialization engine |
| ready | output | 1 | Normal traffic may be issued |
| data_lost | output | 1 | Memory contents were lost by the last deep sleep |

## Verification
The bench sweeps the number of precharge rounds before entry (none, one, two) to separate direct entry from a single precharge and from a repeated bank check. It sweeps the wake arrival from the entry cycle up to six cycles later: early arrivals exercise the minimum low-time hold, and later ones expose the synchronizer latency. It also sweeps the delay of init_done, which confirms that ready follows the engine and not the pause counter. Stray wake pulses while idle and stray sleep pulses during the pause show that both inputs are ignored in the wrong state.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_BST = 3'b110;
  localparam logic [2:0] CMD_NOP = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRP,
    ST_DPD,
    ST_PAUSE,
    ST_INIT
  } dpd_state_t;
endpackage

// File: rtl/dpd_sync.sv
module dpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dpd_cnt.sv
module dpd_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dpd_fsm.sv
module dpd_fsm
  import dpd_pkg::*;
#(
  parameter int SW    = 3,
  parameter int LW    = 16,
  parameter int T_RP  = 4,
  parameter int T_CKE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          wake_s,
  input  logic          any_open,
  input  logic          init_done,
  input  logic          s_zero,
  input  logic          l_zero,
  output logic          s_load,
  output logic [SW-1:0] s_val,
  output logic          l_load,
  output logic [2:0]    cmd,
  output logic          pre_all,
  output logic          cke,
  output logic          sleep_ack,
  output logic          init_start,
  output logic          ready,
  output logic          data_lost
);
  localparam logic [SW-1:0] RP_V  = SW'(T_RP - 1);
  localparam logic [SW-1:0] CKE_V = SW'(T_CKE - 1);

  dpd_state_t st;
  logic decide, go_pre, go_bst, go_exit;

  always_comb begin
    decide  = ((st == ST_IDLE) && sleep_req) || ((st == ST_TRP) && s_zero);
    go_pre  = decide && any_open;
    go_bst  = decide && !any_open;
    go_exit = (st == ST_DPD) && s_zero && wake_s;
    s_load  = go_pre || go_bst;
    s_val   = go_pre ? RP_V : CKE_V;
    l_load  = go_exit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cmd        <= CMD_NOP;
      pre_all    <= 1'b0;
      cke        <= 1'b1;
      sleep_ack  <= 1'b0;
      init_start <= 1'b0;
      ready      <= 1'b1;
      data_lost  <= 1'b0;
    end else begin
      cmd        <= CMD_NOP;
      pre_all    <= 1'b0;
      sleep_ack  <= 1'b0;
      init_start <= 1'b0;
      if (st == ST_IDLE && sleep_req) begin
        ready     <= 1'b0;
        data_lost <= 1'b0;
      end
      if (go_pre) begin
        cmd     <= CMD_PRE;
        pre_all <= 1'b1;
        st      <= ST_TRP;
      end else if (go_bst) begin
        cmd       <= CMD_BST;
        cke       <= 1'b0;
        sleep_ack <= 1'b1;
        st        <= ST_DPD;
      end
      if (go_exit) begin
        cke       <= 1'b1;
        data_lost <= 1'b1;
        st        <= ST_PAUSE;
      end
      if (st == ST_PAUSE && l_zero) begin
        init_start <= 1'b1;
        st         <= ST_INIT;
      end
      if (st == ST_INIT && init_done) begin
        ready <= 1'b1;
        st    <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/dpd_seq.sv
module dpd_seq #(
  parameter int NBANK       = 4,
  parameter int CLK_MHZ     = 200,
  parameter int PAUSE_US    = 200,
  parameter int T_RP        = 4,
  parameter int T_CKE       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic [NBANK-1:0] banks_open,
  input  logic             init_done,
  output logic [2:0]       cmd,
  output logic             pre_all,
  output logic             cke,
  output logic             sleep_ack,
  output logic             init_start,
  output logic             ready,
  output logic             data_lost
);
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int SHORT_MAX = (T_RP > T_CKE) ? T_RP : T_CKE;
  localparam int SW        = $clog2(SHORT_MAX + 1);
  localparam int LW        = $clog2(PAUSE_CYC + 1);
  localparam logic [LW-1:0] PAUSE_V = LW'(PAUSE_CYC - 1);

  logic          wake_s;
  logic          s_load, l_load, s_zero, l_zero;
  logic [SW-1:0] s_val;

  dpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(wake_req), .q(wake_s)
  );

  dpd_cnt #(.W(SW)) u_short (
    .clk(clk), .rst(rst), .load(s_load), .load_val(s_val), .zero(s_zero)
  );

  dpd_cnt #(.W(LW)) u_pause (
    .clk(clk), .rst(rst), .load(l_load), .load_val(PAUSE_V), .zero(l_zero)
  );

  dpd_fsm #(.SW(SW), .LW(LW), .T_RP(T_RP), .T_CKE(T_CKE)) u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_s(wake_s),
    .any_open(|banks_open), .init_done(init_done),
    .s_zero(s_zero), .l_zero(l_zero), .s_load(s_load), .s_val(s_val),
    .l_load(l_load), .cmd(cmd), .pre_all(pre_all), .cke(cke),
    .sleep_ack(sleep_ack), .init_start(init_start), .ready(ready),
    .data_lost(data_lost)
  );
endmodule

// File: rtl/dpd_seq_chk.sv
module dpd_seq_chk #(
  parameter int T_CKE = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd,
  input logic       pre_all,
  input logic       cke,
  input logic       sleep_ack,
  input logic       init_start,
  input logic       ready,
  input logic       data_lost
);
  localparam int CW = $clog2(T_CKE + 1) + 1;
  logic [CW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)                       low_run <= '0;
    else if (cke)                  low_run <= '0;
    else if (low_run < CW'(T_CKE)) low_run <= low_run + 1'b1;
  end

  AST_BST_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b110) |-> !cke); // R2
  AST_ACK_WITH_BST: assert property (@(posedge clk) disable iff (rst)
    sleep_ack |-> (cmd == 3'b110)); // R2
  AST_PREALL_WITH_PRE: assert property (@(posedge clk) disable iff (rst)
    pre_all |-> (cmd == 3'b010)); // R3
  AST_NOP_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (!cke && !sleep_ack) |-> (cmd == 3'b111)); // R4
  AST_CKE_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (low_run >= CW'(T_CKE))); // R5
  AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    init_start |=> !init_start); // R7
  AST_READY_AWAKE: assert property (@(posedge clk) disable iff (rst)
    ready |-> cke); // R8
  AST_LOST_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> data_lost); // R9
endmodule

bind dpd_seq dpd_seq_chk #(.T_CKE(T_CKE)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .pre_all(pre_all), .cke(cke),
  .sleep_ack(sleep_ack), .init_start(init_start), .ready(ready),
  .data_lost(data_lost)
);

// File: tb/dpd_seq_test.sv
module dpd_seq_test;
  localparam int NBANK = 4, CLK_MHZ = 1, PAUSE_US = 10, T_RP = 3, T_CKE = 4, SYNC = 2;
  localparam int P = CLK_MHZ * PAUSE_US;
  localparam logic [2:0] PRE = 3'b010, BST = 3'b110, NOP = 3'b111;

  logic clk = 1'b0, rst = 1'b1, sleep_req = 1'b0, wake_req = 1'b0, init_done = 1'b0;
  logic [NBANK-1:0] banks_open = '0;
  logic [2:0] cmd;
  logic pre_all, cke, sleep_ack, init_start, ready, data_lost;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dpd_seq #(.NBANK(NBANK), .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP),
            .T_CKE(T_CKE), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .banks_open(banks_open), .init_done(init_done), .cmd(cmd), .pre_all(pre_all),
    .cke(cke), .sleep_ack(sleep_ack), .init_start(init_start), .ready(ready),
    .data_lost(data_lost)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic episode(input int r, input int w, input int d);
    int x;
    @(negedge clk);
    banks_open = (r > 0) ? 4'b0101 : 4'b0000;
    sleep_req  = 1'b1;
    for (int k = 0; k < r; k++) begin
      @(negedge clk);
      check("R3 precharge cmd", cmd, PRE);
      check("R3 pre_all", pre_all, 1);
      check("R8 ready low", ready, 0);
      if (k == 0) check("R9 lost cleared", data_lost, 0);
      if (k == r - 1) banks_open = '0;
      for (int j = 1; j < T_RP; j++) begin
        @(negedge clk);
        check("R3 nop in tRP", cmd, NOP);
      end
    end
    @(negedge clk);
    check("R2 entry cmd", cmd, BST);
    check("R2 cke low", cke, 0);
    check("R2 ack", sleep_ack, 1);
    check("R2 ready low", ready, 0);
    if (r == 0) check("R9 lost cleared", data_lost, 0);
    sleep_req = 1'b0;
    if (w == 0) wake_req = 1'b1;
    x = (w + SYNC + 1 > T_CKE) ? w + SYNC + 1 : T_CKE;
    for (int i = 1; i <= x; i++) begin
      @(negedge clk);
      if (i < x) begin
        check("R5 cke held low", cke, 0);
        check("R4 nop asleep", cmd, NOP);
        check("R2 ack one cycle", sleep_ack, 0);
      end else begin
        check("R6 cke raised", cke, 1);
        check("R9 lost on exit", data_lost, 1);
        wake_req = 1'b0;
      end
      if (i == w) wake_req = 1'b1;
    end
    for (int i = 1; i <= P; i++) begin
      @(negedge clk);
      check("R4 nop in pause", cmd, NOP);
      check("R7 cke high", cke, 1);
      check("R10 no ack in pause", sleep_ack, 0);
      check("R7 init_start", init_start, (i == P) ? 1 : 0);
      if (i == 1) sleep_req = 1'b1;
      if (i == 2) sleep_req = 1'b0;
    end
    if (d == 0) init_done = 1'b1;
    for (int i = 1; i <= d + 1; i++) begin
      @(negedge clk);
      if (i == 1) check("R7 pulse ends", init_start, 0);
      if (i <= d) begin
        check("R8 ready waits", ready, 0);
        if (i == d) init_done = 1'b1;
      end else begin
        check("R8 ready after done", ready, 1);
        check("R9 lost held", data_lost, 1);
        init_done = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements): actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cke", cke, 1);
    check("R1 ready", ready, 1);
    check("R1 cmd", cmd, NOP);
    check("R1 ack", sleep_ack, 0);
    check("R1 init_start", init_start, 0);
    check("R1 data_lost", data_lost, 0);
    check("R1 pre_all", pre_all, 0);
    rst = 1'b0;
    wake_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10 wake idle cke", cke, 1);
      check("R10 wake idle cmd", cmd, NOP);
      check("R10 wake idle ready", ready, 1);
    end
    wake_req = 1'b0;
    repeat (4) @(negedge clk);
    for (int r = 0; r < 3; r++)
      for (int w = 0; w < 7; w++)
        for (int d = 0; d < 3; d++)
          episode(r, w, d);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule